// File: doc/BRIEF.md
# Lockable Fault-to-Break Routing Register

This block gathers several system fault indications and steers them onto one shared emergency-stop line that feeds the timers' break inputs. There are five fault sources: a processor lockup, a main SRAM parity error, a supply-voltage monitor event, a flash double-bit ECC error and a backup SRAM parity error. Each source has its own route-enable bit. Software can set a route-enable bit but cannot clear it, so the bit also acts as a lock that holds until system reset.

The same register holds two sticky parity-error flags. Hardware sets them and software clears them by writing 1. A second register sits next to it and holds the voltage monitor's enable bit and its 3-bit threshold. Once the voltage-monitor route is enabled, both of those fields are frozen. Access goes through a simple single-cycle register bus, and reads have no side effects.

Top module: `fault_brk_route`

## Requirements
- R1: After reset, the routing register (offset 0x0), the power control register (offset 0x4), the break output, the monitor enable output and the threshold output are all 0.
- R2: A write to offset 0x0 sets each route bit whose write-data bit is 1. The route bits are: bit 0 lockup, bit 1 main SRAM parity, bit 2 voltage monitor, bit 3 flash ECC, bit 4 backup SRAM parity. Writing 0 never clears a set route bit. Only reset clears it.
- R3: The break output is the OR of every fault input whose route bit is 1. It follows the fault inputs combinationally, in the same cycle.
- R4: A fault input whose route bit is 0 has no effect on the break output. With no fault input active, the break output is 0.
- R5: A main SRAM parity error sets the flag at bit 8 and a backup SRAM parity error sets the flag at bit 7, one cycle later. This happens whether or not the matching route bit is set.
- R6: Writing 1 to a flag bit at offset 0x0 clears that flag. Writing 0 leaves it unchanged.
- R7: If a hardware set and a software clear of the same flag fall in the same cycle, the flag ends up 1.
- R8: While route bit 2 is 0, a write to offset 0x4 loads the monitor enable from bit 0 and the threshold from bits 3:1. Both values read back and appear on the monitor outputs.
- R9: While route bit 2 is 1, writes to offset 0x4 leave the monitor enable and the threshold unchanged.
- R10: Unused bits in both registers read 0 and ignore writes. Any other offset reads 0, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W (4) | Byte offset of the register |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for bus_addr |
| cpu_lockup_i | input | 1 | Processor lockup indication |
| sram_par_err_i | input | 1 | Main SRAM parity error |
| vmon_evt_i | input | 1 | Voltage monitor event |
| ecc_dbl_err_i | input | 1 | Flash double-bit ECC error |
| bkp_par_err_i | input | 1 | Backup SRAM parity error |
| brk_o | output | 1 | Shared break request to the timers |
| vmon_en_o | output | 1 | Voltage monitor enable field |
| vmon_thr_o | output | THR_W (3) | Voltage monitor threshold field |

## Verification
The bench uses the default parameters: a 32-bit data bus, a 4-bit offset, five routes and a 3-bit threshold. This configuration is small enough to sweep completely. For every one of the 32 route settings (applied after a fresh reset), the bench drives all 32 fault patterns. It also tries all 16 writes to the power register, both before and after the lock is set. That covers every pairing of route enable and fault and every field value. The remaining cases are handled one by one: the set-wins collision, stickiness after zero writes, and writes to unused bits and offsets.

// File: rtl/fbr_pkg.sv
package fbr_pkg;
    localparam int N_SRC      = 5;
    localparam int SRC_LOCKUP = 0;
    localparam int SRC_SRAM   = 1;
    localparam int SRC_VMON   = 2;
    localparam int SRC_ECC    = 3;
    localparam int SRC_BKP    = 4;

    localparam int N_FLG      = 2;
    localparam int FLG_BKP    = 0;
    localparam int FLG_MAIN   = 1;
    localparam int FLG_LSB    = 7;

    localparam int PWR_EN_BIT = 0;
    localparam int THR_LSB    = 1;
endpackage

// File: rtl/fbr_route_ctl.sv
module fbr_route_ctl #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [N-1:0] set_bits,
    input  logic [N-1:0] fault_i,
    output logic [N-1:0] route_o,
    output logic         brk_o
);
    typedef struct packed {
        logic [N-1:0] en;
    } st_t;

    st_t st_d, st_q;
    logic [N-1:0] gated;

    always_comb begin
        st_d = st_q;
        if (set_we) begin
            st_d.en = st_q.en | set_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gated[g] = st_q.en[g] & fault_i[g];
    end

    assign route_o = st_q.en;
    assign brk_o   = |gated;

    // R2: a route bit, once set, never falls before reset
    a_r2_route_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((route_o & $past(route_o)) == $past(route_o)));
endmodule

// File: rtl/fbr_par_flags.sv
module fbr_par_flags #(
    parameter int NF = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set_i,
    input  logic          clr_we,
    input  logic [NF-1:0] clr_bits,
    output logic [NF-1:0] flag_o
);
    typedef struct packed {
        logic [NF-1:0] flg;
    } st_t;

    st_t st_d, st_q;
    logic [NF-1:0] clr_eff;

    assign clr_eff = clr_we ? clr_bits : '0;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NF; i++) begin
            if (set_i[i])        st_d.flg[i] = 1'b1;
            else if (clr_eff[i]) st_d.flg[i] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flg;

    // R5/R7: a hardware set is always visible one cycle later
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_o & $past(set_i)) == $past(set_i)));
    // R6: without a set or a clear the flags hold
    a_r6_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((set_i | clr_eff) == '0) |=> $stable(flag_o));
endmodule

// File: rtl/fbr_pwr_ctl.sv
module fbr_pwr_ctl #(
    parameter int THR_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             en_wd,
    input  logic [THR_W-1:0] thr_wd,
    input  logic             lock_i,
    output logic             en_o,
    output logic [THR_W-1:0] thr_o
);
    typedef struct packed {
        logic             en;
        logic [THR_W-1:0] thr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we && !lock_i) begin
            st_d.en  = en_wd;
            st_d.thr = thr_wd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign thr_o = st_q.thr;

    // R9: locked fields cannot move
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        lock_i |=> ($stable(en_o) && $stable(thr_o)));
endmodule

// File: rtl/fault_brk_route.sv
module fault_brk_route
    import fbr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4,
    parameter int CFG_OFS = 0,
    parameter int PWR_OFS = 4,
    parameter int THR_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              cpu_lockup_i,
    input  logic              sram_par_err_i,
    input  logic              vmon_evt_i,
    input  logic              ecc_dbl_err_i,
    input  logic              bkp_par_err_i,
    output logic              brk_o,
    output logic              vmon_en_o,
    output logic [THR_W-1:0]  vmon_thr_o
);
    localparam int FLG_MSB = FLG_LSB + N_FLG - 1;
    localparam int THR_MSB = THR_LSB + THR_W - 1;

    logic             cfg_sel, pwr_sel;
    logic [N_SRC-1:0] fault_vec, route;
    logic [N_FLG-1:0] flag_set, flags;
    logic             unused_wdata;

    assign cfg_sel = (bus_addr == ADDR_W'(CFG_OFS));
    assign pwr_sel = (bus_addr == ADDR_W'(PWR_OFS));

    always_comb begin
        fault_vec             = '0;
        fault_vec[SRC_LOCKUP] = cpu_lockup_i;
        fault_vec[SRC_SRAM]   = sram_par_err_i;
        fault_vec[SRC_VMON]   = vmon_evt_i;
        fault_vec[SRC_ECC]    = ecc_dbl_err_i;
        fault_vec[SRC_BKP]    = bkp_par_err_i;
        flag_set              = '0;
        flag_set[FLG_BKP]     = bkp_par_err_i;
        flag_set[FLG_MAIN]    = sram_par_err_i;
    end

    fbr_route_ctl #(.N(N_SRC)) i_route (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_we   (bus_we && cfg_sel),
        .set_bits (bus_wdata[N_SRC-1:0]),
        .fault_i  (fault_vec),
        .route_o  (route),
        .brk_o    (brk_o)
    );

    fbr_par_flags #(.NF(N_FLG)) i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (flag_set),
        .clr_we   (bus_we && cfg_sel),
        .clr_bits (bus_wdata[FLG_MSB:FLG_LSB]),
        .flag_o   (flags)
    );

    fbr_pwr_ctl #(.THR_W(THR_W)) i_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (bus_we && pwr_sel),
        .en_wd  (bus_wdata[PWR_EN_BIT]),
        .thr_wd (bus_wdata[THR_MSB:THR_LSB]),
        .lock_i (route[SRC_VMON]),
        .en_o   (vmon_en_o),
        .thr_o  (vmon_thr_o)
    );

    assign unused_wdata = ^{bus_wdata};

    always_comb begin
        bus_rdata = '0;
        if (cfg_sel) begin
            bus_rdata[N_SRC-1:0]       = route;
            bus_rdata[FLG_MSB:FLG_LSB] = flags;
        end else if (pwr_sel) begin
            bus_rdata[PWR_EN_BIT]      = vmon_en_o;
            bus_rdata[THR_MSB:THR_LSB] = vmon_thr_o;
        end
    end

    // R4: no fault input active means no break
    a_r4_idle_no_brk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_vec == '0) |-> !brk_o);
    // R10: unmapped offsets read as zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sel && !pwr_sel) |-> (bus_rdata == '0));
endmodule

// File: tb/test_fault_brk_route.sv
module test_fault_brk_route;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        cpu_lockup_i = 1'b0, sram_par_err_i = 1'b0, vmon_evt_i = 1'b0;
    logic        ecc_dbl_err_i = 1'b0, bkp_par_err_i = 1'b0;
    logic        brk_o, vmon_en_o;
    logic [2:0]  vmon_thr_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fault_brk_route i_fault_brk_route (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cpu_lockup_i(cpu_lockup_i), .sram_par_err_i(sram_par_err_i),
        .vmon_evt_i(vmon_evt_i), .ecc_dbl_err_i(ecc_dbl_err_i),
        .bkp_par_err_i(bkp_par_err_i), .brk_o(brk_o),
        .vmon_en_o(vmon_en_o), .vmon_thr_o(vmon_thr_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bus_we = 1'b0;
        {cpu_lockup_i, sram_par_err_i, vmon_evt_i, ecc_dbl_err_i, bkp_par_err_i} = '0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata, exp, req);
    endtask

    task automatic set_faults(input logic [4:0] f);
        cpu_lockup_i   = f[0];
        sram_par_err_i = f[1];
        vmon_evt_i     = f[2];
        ecc_dbl_err_i  = f[3];
        bkp_par_err_i  = f[4];
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [3:0] pv;
        do_reset();
        // R1: reset state
        rd_chk(4'h0, 32'h0, "R1 cfg");
        rd_chk(4'h4, 32'h0, "R1 pwr");
        check({31'b0, brk_o}, 32'h0, "R1 brk");
        check({28'b0, vmon_thr_o, vmon_en_o}, 32'h0, "R1 mon outs");

        // R8: unlocked power register sweep with junk upper bits
        for (int v = 0; v < 16; v++) begin
            wr(4'h4, 32'hFFFF_FFF0 | v);
            rd_chk(4'h4, v, "R8 readback");
            check({28'b0, vmon_thr_o, vmon_en_o}, v, "R8 outputs");
        end
        pv = 4'hF;
        wr(4'h4, 32'h0000_000A);
        pv = 4'hA;
        // R2: set the voltage-monitor route, which locks
        wr(4'h0, 32'h0000_0004);
        rd_chk(4'h0, 32'h4, "R2 set vmon route");
        // R9: locked sweep
        for (int v = 0; v < 16; v++) begin
            wr(4'h4, v);
            rd_chk(4'h4, {28'b0, pv}, "R9 locked readback");
            check({28'b0, vmon_thr_o, vmon_en_o}, {28'b0, pv}, "R9 locked outputs");
        end
        wr(4'h0, 32'h0);
        rd_chk(4'h0, 32'h4, "R2 zero write keeps lock");

        // Flags
        do_reset();
        @(negedge clk); sram_par_err_i = 1'b1;
        @(negedge clk); sram_par_err_i = 1'b0;
        rd_chk(4'h0, 32'h100, "R5 main flag");
        check({31'b0, brk_o}, 32'h0, "R4 unrouted parity");
        @(negedge clk); bkp_par_err_i = 1'b1;
        @(negedge clk); bkp_par_err_i = 1'b0;
        rd_chk(4'h0, 32'h180, "R5 backup flag");
        rd_chk(4'h0, 32'h180, "R10 read has no side effect");
        wr(4'h0, 32'h0);
        rd_chk(4'h0, 32'h180, "R6 zero write keeps flags");
        wr(4'h0, 32'h80);
        rd_chk(4'h0, 32'h100, "R6 clear backup flag");
        // R7: set and clear collide
        @(negedge clk);
        bus_addr = 4'h0; bus_wdata = 32'h100; bus_we = 1'b1; sram_par_err_i = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; sram_par_err_i = 1'b0;
        rd_chk(4'h0, 32'h100, "R7 set wins");
        wr(4'h0, 32'h100);
        rd_chk(4'h0, 32'h0, "R6 clear main flag");

        // R10: unused bits and offsets
        wr(4'h0, 32'hFFFF_FE60);
        rd_chk(4'h0, 32'h0, "R10 unused cfg bits");
        wr(4'h8, 32'hFFFF_FFFF);
        rd_chk(4'h8, 32'h0, "R10 unmapped read");
        rd_chk(4'h0, 32'h0, "R10 unmapped write cfg");
        rd_chk(4'h4, 32'h0, "R10 unmapped write pwr");

        // R2/R3/R4: exhaustive route x fault sweep
        for (int r = 0; r < 32; r++) begin
            do_reset();
            rd_chk(4'h0, 32'h0, "R1 after reset");
            wr(4'h0, r);
            rd_chk(4'h0, r, "R2 route set");
            for (int f = 0; f < 32; f++) begin
                @(negedge clk);
                set_faults(5'(f));
                #1;
                check({31'b0, brk_o}, {31'b0, ((r & f) != 0)}, "R3 R4 break");
            end
            @(negedge clk);
            set_faults(5'd0);
            wr(4'h0, 32'h180);
            rd_chk(4'h0, r, "R2 zero route write no clear");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule